// File: doc/BRIEF.md
# Sleep Timer Compare Unit

A free-running sleep counter with two independent compare channels (A and B) and a wrap event. Each channel's compare value is twice the width of a register half, so software loads it in two steps: the low half goes into a per-channel hold register, and a write to the high half moves the held low half and the new high half into the active compare value on the same clock edge. The compare value cannot then be seen in a half-updated state.

Three sticky event flags record counter wrap, compare A match and compare B match. Software clears a flag by writing one to its bit. A mask register chooses which flags drive the single interrupt output. Compare values are meant to be changed only while the counter is stopped. A commit made while it runs raises that channel's flag if the new value equals the current count. The counter advances on a `tick_en` pulse from the clock and prescale logic outside the block.

Register access is a simple synchronous bus. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. Addresses are word indices. The counter width `CNT_W` is a parameter (default 32), and each register half is `CNT_W/2` bits wide.

Top module: `sleep_cmp_top`

## Requirements
- R1: After reset the control, flag and mask registers and the counter read 0. Each channel's active compare value reads with its low half all ones (0x0000FFFF at the default width) and its high half 0.
- R2: The counter, readable at address 7, goes up by exactly one on each clock edge where `tick_en` is 1 and the run bit (bit 11 of the control register at address 0) is 1. Otherwise it holds its value.
- R3: A write to a channel's low-half address (A: 1, B: 3) loads only that channel's hold register and leaves the active compare value unchanged. A read of the low-half address returns the active low half, not the hold register.
- R4: A write to a channel's high-half address (A: 2, B: 4) loads the active high half from the write data and the active low half from that channel's hold register, both on the same edge. Each channel has its own hold register.
- R5: On a tick where the counter steps to a value equal to a channel's active compare value, that channel's flag is set: bit 1 for A and bit 2 for B of the flag register at address 5.
- R6: On a tick where the counter steps from all ones to 0, flag bit 0 (wrap) is set. No wrap flag is raised on any other step.
- R7: Flags stay set until cleared. Writing to address 5 clears exactly the flag bits written as 1. Bits written as 0 have no effect.
- R8: When a flag's set event and a clear of the same bit happen on the same edge, the flag ends up set.
- R9: A high-half commit made while the run bit is 1, where the new compare value equals the current count, sets that channel's flag. The same commit made while the run bit is 0 does not set it.
- R10: `irq` is 1 exactly when some flag bit is 1 and the same bit of the 3-bit mask register at address 6 is 1.
- R11: Reserved bits read as 0. These are all control bits except bit 11, flag and mask bits above bit 2, and compare read bits above the half width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count-enable pulse from the sleep clock prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq | output | 1 | Masked OR of the event flags |

## Verification
The compare path is tried with a low-half write on its own, a low-half write followed by a commit, and interleaved writes to both channels. These cases separate a correct hold-and-commit from a design that writes straight through or shares one hold register. Matches are reached by counting with the run bit both on and off, which separates a tick-driven count from one that is free-running. A clear is placed on the same edge as a match to show whether set wins over clear. Commits that equal the current count are made with the run bit off and then on, which shows whether the spurious-match rule depends on the run bit. The wrap case runs a reduced-width counter through all ones, which shows whether the wrap flag is raised on exactly that step.

// File: rtl/sleep_cmp_pkg.sv
package sleep_cmp_pkg;

  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned N_CH      = 2;
  localparam int unsigned N_FLAG    = N_CH + 1;
  localparam int unsigned RUN_BIT   = 11;
  localparam int unsigned WRAP_FLAG = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_A_LO  = 3'd1,
    REG_A_HI  = 3'd2,
    REG_B_LO  = 3'd3,
    REG_B_HI  = 3'd4,
    REG_FLAGS = 3'd5,
    REG_MASK  = 3'd6,
    REG_COUNT = 3'd7
  } reg_addr_e;

  // channel ch owns low half at 1+2*ch, high half at 2+2*ch, flag bit 1+ch
  function automatic logic [ADDR_W-1:0] lo_addr(input int unsigned ch);
    return ADDR_W'(1 + 2 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] hi_addr(input int unsigned ch);
    return ADDR_W'(2 + 2 * ch);
  endfunction

endpackage

// File: rtl/sleep_cmp_counter.sv
module sleep_cmp_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             step,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    step    = run & tick_en;
    cnt_nxt = cnt_q + 1'b1;
    wrap    = step & (&cnt_q);
    cnt_d   = step ? cnt_nxt : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sleep_cmp_channel.sv
module sleep_cmp_channel #(
  parameter int unsigned CNT_W = 32,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  input  logic              run,
  input  logic              step,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  cnt_nxt,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              hit
);

  logic [HALF_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0]  cmp_d;
  logic [CNT_W-1:0]  staged;
  logic              tick_hit, late_hit;

  always_comb begin
    staged   = {wdata, hold_q};
    hold_d   = wr_lo ? wdata : hold_q;
    cmp_d    = wr_hi ? staged : cmp_q;
    tick_hit = step & (cnt_nxt == cmp_q);
    late_hit = wr_hi & run & (staged == cnt_q);
    hit      = tick_hit | late_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '1;
      cmp_q  <= {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    end else begin
      hold_q <= hold_d;
      cmp_q  <= cmp_d;
    end
  end

endmodule

// File: rtl/sleep_cmp_flags.sv
module sleep_cmp_flags #(
  parameter int unsigned N_FLAG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FLAG-1:0] set_ev,
  input  logic              wr_flags,
  input  logic              wr_mask,
  input  logic [N_FLAG-1:0] wdata,
  output logic [N_FLAG-1:0] flag_q,
  output logic [N_FLAG-1:0] mask_q,
  output logic              irq
);

  logic [N_FLAG-1:0] flag_d, mask_d, clr;

  always_comb begin
    clr    = wr_flags ? wdata : '0;
    flag_d = (flag_q & ~clr) | set_ev;
    mask_d = wr_mask ? wdata : mask_q;
    irq    = |(flag_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/sleep_cmp_top.sv
module sleep_cmp_top
  import sleep_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int unsigned HALF_W = CNT_W / 2;

  logic [1:0]        rst_sync;
  logic              rst_n_s;
  logic              run_q, run_d;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              step, wrap;
  logic [CNT_W-1:0]  cmp_q [N_CH];
  logic [N_CH-1:0]   ch_hit;
  logic [N_FLAG-1:0] set_ev, flag_q, mask_q;
  logic              wr_flags, wr_mask;
  logic              unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  always_comb begin
    run_d = (bus_wr && bus_addr == REG_CTRL) ? bus_wdata[RUN_BIT] : run_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) run_q <= 1'b0;
    else          run_q <= run_d;
  end

  sleep_cmp_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run    (run_q),
    .tick_en(tick_en),
    .cnt_q  (cnt_q),
    .cnt_nxt(cnt_nxt),
    .step   (step),
    .wrap   (wrap)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    sleep_cmp_channel #(.CNT_W(CNT_W)) ch_i (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .wr_lo  (bus_wr && bus_addr == lo_addr(ch)),
      .wr_hi  (bus_wr && bus_addr == hi_addr(ch)),
      .wdata  (bus_wdata[HALF_W-1:0]),
      .run    (run_q),
      .step   (step),
      .cnt_q  (cnt_q),
      .cnt_nxt(cnt_nxt),
      .cmp_q  (cmp_q[ch]),
      .hit    (ch_hit[ch])
    );
  end

  assign set_ev   = {ch_hit, wrap};
  assign wr_flags = bus_wr && bus_addr == REG_FLAGS;
  assign wr_mask  = bus_wr && bus_addr == REG_MASK;

  sleep_cmp_flags #(.N_FLAG(N_FLAG)) flg_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .set_ev  (set_ev),
    .wr_flags(wr_flags),
    .wr_mask (wr_mask),
    .wdata   (bus_wdata[N_FLAG-1:0]),
    .flag_q  (flag_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL:  bus_rdata[RUN_BIT] = run_q;
      REG_A_LO:  bus_rdata = DATA_W'(cmp_q[0][HALF_W-1:0]);
      REG_A_HI:  bus_rdata = DATA_W'(cmp_q[0][CNT_W-1:HALF_W]);
      REG_B_LO:  bus_rdata = DATA_W'(cmp_q[1][HALF_W-1:0]);
      REG_B_HI:  bus_rdata = DATA_W'(cmp_q[1][CNT_W-1:HALF_W]);
      REG_FLAGS: bus_rdata = DATA_W'(flag_q);
      REG_MASK:  bus_rdata = DATA_W'(mask_q);
      REG_COUNT: bus_rdata = DATA_W'(cnt_q);
      default:   bus_rdata = '0;
    endcase
  end

  assign unused_wbits = &{1'b0, bus_wdata};

endmodule

// File: rtl/sleep_cmp_chk.sv
module sleep_cmp_chk
  import sleep_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              run_q,
  input logic              tick_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  cmp_a,
  input logic [CNT_W-1:0]  cmp_b,
  input logic [N_FLAG-1:0] flag_q,
  input logic [N_FLAG-1:0] mask_q,
  input logic              irq
);

  logic [N_FLAG-1:0] clr_v, keep_v;
  logic              adv;

  always_comb begin
    clr_v  = (bus_wr && bus_addr == REG_FLAGS) ? bus_wdata[N_FLAG-1:0] : '0;
    keep_v = flag_q & ~clr_v;
    adv    = run_q & tick_en;
  end

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !adv |=> $stable(cnt_q));

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    adv |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_lo_keeps_active_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == REG_A_LO) |=> $stable(cmp_a));

  assert_lo_keeps_active_b_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == REG_B_LO) |=> $stable(cmp_b));

  assert_match_b_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (adv && (cnt_q + 1'b1) == cmp_b) |=> flag_q[2]);

  assert_wrap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (adv && (&cnt_q)) |=> flag_q[WRAP_FLAG]);

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (keep_v != '0) |=> ((flag_q & $past(keep_v)) == $past(keep_v)));

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mask_q == '0) |-> !irq);

endmodule

bind sleep_cmp_top sleep_cmp_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n_s  (rst_n_s),
  .run_q    (run_q),
  .tick_en  (tick_en),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .cnt_q    (cnt_q),
  .cmp_a    (cmp_q[0]),
  .cmp_b    (cmp_q[1]),
  .flag_q   (flag_q),
  .mask_q   (mask_q),
  .irq      (irq)
);

// File: tb/sleep_cmp_top_tb_top.sv
module sleep_cmp_top_tb_top;

  localparam int unsigned CW = 12;
  localparam logic [2:0] A_CTRL = 3'd0, A_ALO = 3'd1, A_AHI = 3'd2, A_BLO = 3'd3,
                         A_BHI = 3'd4, A_FLG = 3'd5, A_MSK = 3'd6, A_CNT = 3'd7;
  localparam logic [31:0] RUN = 32'h0000_0800;

  logic        clk = 1'b0;
  logic        rst_n, tick_en, bus_wr, irq;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  sleep_cmp_top #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", A_CTRL, 32'h0);
    rd_chk("R1 a_lo", A_ALO, 32'h3F);
    rd_chk("R1 a_hi", A_AHI, 32'h0);
    rd_chk("R1 b_lo", A_BLO, 32'h3F);
    rd_chk("R1 flags", A_FLG, 32'h0);
    rd_chk("R1 mask", A_MSK, 32'h0);
    rd_chk("R1 count", A_CNT, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_hold_commit();
    wr(A_ALO, 32'h05);
    rd_chk("R3 a_lo unchanged", A_ALO, 32'h3F);
    wr(A_AHI, 32'h01);
    rd_chk("R4 a_lo committed", A_ALO, 32'h05);
    rd_chk("R4 a_hi committed", A_AHI, 32'h01);
    wr(A_BLO, 32'hFFFF_FF0A);
    rd_chk("R4 own hold a", A_ALO, 32'h05);
    wr(A_BHI, 32'h0);
    rd_chk("R4 b_lo committed", A_BLO, 32'h0A);
    rd_chk("R11 b_hi width", A_BHI, 32'h0);
  endtask

  task automatic t_count_match();
    wr(A_CTRL, RUN);
    rd_chk("R2 no tick no count", A_CNT, 32'h0);
    ticks(10);
    rd_chk("R2 count 10", A_CNT, 32'd10);
    rd_chk("R5 b match", A_FLG, 32'h4);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(A_MSK, 32'h4);
    chk("R10 irq on", {31'b0, irq}, 32'h1);
    wr(A_MSK, 32'h2);
    chk("R10 irq other bit", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_w1c();
    wr(A_FLG, 32'h0);
    rd_chk("R7 zero write", A_FLG, 32'h4);
    wr(A_FLG, 32'h4);
    rd_chk("R7 clear b", A_FLG, 32'h0);
    ticks(59);
    rd_chk("R2 count 69", A_CNT, 32'd69);
    rd_chk("R5 a match", A_FLG, 32'h2);
    chk("R10 irq a", {31'b0, irq}, 32'h1);
    wr(A_FLG, 32'h1);
    rd_chk("R7 other bit kept", A_FLG, 32'h2);
  endtask

  task automatic t_priority();
    wr(A_CTRL, 32'h0);
    ticks(3);
    rd_chk("R2 stopped", A_CNT, 32'd69);
    wr(A_FLG, 32'h2);
    wr(A_BLO, 32'h05);
    wr(A_BHI, 32'h01);
    rd_chk("R9 no flag when stopped", A_FLG, 32'h0);
    wr(A_BLO, 32'h08);
    wr(A_BHI, 32'h01);
    wr(A_CTRL, RUN);
    ticks(2);
    rd_chk("R2 count 71", A_CNT, 32'd71);
    @(negedge clk);
    tick_en = 1'b1; bus_wr = 1'b1; bus_addr = A_FLG; bus_wdata = 32'h4;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    rd_chk("R8 set beats clear", A_FLG, 32'h4);
    rd_chk("R2 count 72", A_CNT, 32'd72);
  endtask

  task automatic t_late_commit();
    wr(A_ALO, 32'h08);
    rd_chk("R3 lo write no flag", A_FLG, 32'h4);
    wr(A_AHI, 32'h01);
    rd_chk("R9 commit at count", A_FLG, 32'h6);
  endtask

  task automatic t_wrap();
    wr(A_FLG, 32'hFFFF_FFFF);
    rd_chk("R7 clear all", A_FLG, 32'h0);
    ticks(4023);
    rd_chk("R6 at all ones", A_CNT, 32'hFFF);
    rd_chk("R6 no early wrap", A_FLG, 32'h0);
    ticks(1);
    rd_chk("R6 rolled", A_CNT, 32'h0);
    rd_chk("R6 wrap flag", A_FLG, 32'h1);
  endtask

  task automatic t_reserved();
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd_chk("R11 ctrl", A_CTRL, RUN);
    wr(A_MSK, 32'hFFFF_FFFF);
    rd_chk("R11 mask", A_MSK, 32'h7);
    chk("R10 irq wrap", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_hold_commit();
    t_count_match();
    t_w1c();
    t_priority();
    t_late_commit();
    t_wrap();
    t_reserved();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule